// File: doc/BRIEF.md
# Address Quadrant Context Resolver

This block takes a 64-bit effective address and works out which partition identifier and which process identifier a later translation step should use. The selection comes from the two highest address bits (the quadrant) and from whether the requester runs in hypervisor mode. The current partition-ID and process-ID register values are given as inputs. Each quadrant either passes one of these values through or forces it to zero.

The block also decides whether the address may be translated at all. It rejects any address that has a bit set between the top of the usable virtual range and the quadrant bits. Outside hypervisor mode it also rejects quadrants 1 and 2. A rejected request raises a segment fault, and the access kind picks its type. An instruction fetch gets an instruction-segment fault. A load or a store gets a data-segment fault, and the faulting address is captured in a fault-address register. A segment fault carries no separate error code; only its type and, for data accesses, the captured address are reported.

A request is sampled on a valid strobe. One clock later the block returns the result together with a single-cycle done pulse. The result is the success flag, the two identifiers and the fault type. Requests may arrive on back-to-back cycles.

Top module: `aqcr_top`

## Requirements
- R1: While reset is low, and in the cycle after it is released, rsp_done and rsp_ok are 0, rsp_lpid and rsp_pid are 0, rsp_fault is 0 (none) and fault_addr is 0.
- R2: rsp_done is 1 in exactly the cycle after a cycle in which req_valid was 1 at the clock edge, and 0 otherwise. All result outputs belong to that sampled request.
- R3: A request whose address has any bit set in positions [61:52] (default sizes) fails, whatever its quadrant and mode.
- R4: In hypervisor mode (req_hv=1), quadrant 0 (address bits [63:62]=00) yields partition 0 with the current process ID. Quadrant 1 (01) yields the current partition ID with the current process ID.
- R5: In hypervisor mode, quadrant 2 (10) yields the current partition ID with process 0. Quadrant 3 (11) yields partition 0 with process 0.
- R6: Outside hypervisor mode (req_hv=0), quadrant 0 yields the current partition ID with the current process ID. Quadrant 3 yields the current partition ID with process 0.
- R7: Outside hypervisor mode, quadrants 1 and 2 fail.
- R8: A failed fetch (req_kind 2, or code 3, which is treated as a fetch) reports rsp_fault=1 (instruction segment) and leaves fault_addr unchanged.
- R9: A failed load (req_kind 0) or store (req_kind 1) reports rsp_fault=2 (data segment) and loads fault_addr with the request's full address.
- R10: A successful request reports rsp_ok=1, rsp_fault=0 and leaves fault_addr unchanged. A failed request reports rsp_ok=0 and zero on both identifier outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request strobe; inputs are sampled when high |
| req_addr | input | 64 | Effective address |
| req_hv | input | 1 | Requester runs in hypervisor mode |
| req_kind | input | 2 | Access kind: 0 load, 1 store, 2 or 3 fetch |
| cur_lpid | input | 12 | Current partition-ID register value |
| cur_pid | input | 20 | Current process-ID register value |
| rsp_done | output | 1 | One-cycle result pulse |
| rsp_ok | output | 1 | Translation context is valid |
| rsp_lpid | output | 12 | Selected partition ID |
| rsp_pid | output | 20 | Selected process ID |
| rsp_fault | output | 2 | 0 none, 1 instruction segment, 2 data segment |
| fault_addr | output | 64 | Address captured on the latest data-segment fault |

## Verification
The assertions in the RTL check on every cycle the properties that follow from a single sampled request. These are the done timing, the rejection of out-of-range addresses, the rejection of the two quadrants forbidden outside hypervisor mode, zero identifiers on failure, and the fault-address capture or hold for each fault type. The full quadrant table can only be shown by the bench scenarios, which compare identifiers against a model over both modes and all quadrants. So can the reset values and the behaviour of fault_addr over long mixes of successful and failed requests of every access kind.

// File: rtl/aqcr_pkg.sv
// Package: shared encodings for the address quadrant context resolver.
// Assumes a 2-bit access-kind code and a 2-bit fault code.
package aqcr_pkg;

    // Access kind driven by the requester; code 3 behaves as a fetch.
    typedef enum logic [1:0] {
        ACC_LOAD      = 2'd0,
        ACC_STORE     = 2'd1,
        ACC_FETCH     = 2'd2,
        ACC_FETCH_ALT = 2'd3
    } acc_kind_e;

    // Fault type reported with each result.
    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_ISEG = 2'd1,
        FLT_DSEG = 2'd2,
        FLT_RSVD = 2'd3
    } fault_kind_e;

endpackage

// File: rtl/aqcr_range_chk.sv
// Module: splits the upper address bits into the quadrant and the
// reserved hole between the usable range and the quadrant.
// Assumes ADDR_W-2 > VA_BITS is not required; an empty hole always passes.
module aqcr_range_chk #(
    parameter int ADDR_W  = 64,
    parameter int VA_BITS = 52
) (
    input  logic [ADDR_W-1:VA_BITS] hi_bits,
    output logic [1:0]              quad,
    output logic                    in_range
);
    localparam int HOLE_W = ADDR_W - 2 - VA_BITS;

    assign quad = hi_bits[ADDR_W-1:ADDR_W-2];

    generate
        if (HOLE_W > 0) begin : g_hole
            // Any bit set in the hole makes the address unusable.
            assign in_range = ~|hi_bits[ADDR_W-3:VA_BITS];
        end else begin : g_nohole
            assign in_range = 1'b1;
        end
    endgenerate
endmodule

// File: rtl/aqcr_quad_decode.sv
// Module: maps quadrant and privilege mode to the partition/process ID pair.
// Assumes the caller already holds the current ID register values.
module aqcr_quad_decode #(
    parameter int LPID_W = 12,
    parameter int PID_W  = 20
) (
    input  logic [1:0]        quad,
    input  logic              hv,
    input  logic [LPID_W-1:0] cur_lpid,
    input  logic [PID_W-1:0]  cur_pid,
    output logic              legal,
    output logic [LPID_W-1:0] sel_lpid,
    output logic [PID_W-1:0]  sel_pid
);
    // Per-quadrant selection masks, bit index = quadrant number.
    localparam logic [3:0] HV_USE_LPID = 4'b0110;
    localparam logic [3:0] HV_USE_PID  = 4'b0011;
    localparam logic [3:0] GU_USE_LPID = 4'b1001;
    localparam logic [3:0] GU_USE_PID  = 4'b0001;
    localparam logic [3:0] GU_LEGAL    = 4'b1001;

    logic [3:0] quad_hot;
    logic       use_lpid;
    logic       use_pid;

    // One-hot quadrant select, one line per quadrant.
    generate
        for (genvar q = 0; q < 4; q++) begin : g_quad
            assign quad_hot[q] = (quad == q[1:0]);
        end
    endgenerate

    // Pick the mode's table row and gate the identifiers with it.
    always_comb begin
        if (hv) begin
            legal    = 1'b1;
            use_lpid = |(quad_hot & HV_USE_LPID);
            use_pid  = |(quad_hot & HV_USE_PID);
        end else begin
            legal    = |(quad_hot & GU_LEGAL);
            use_lpid = |(quad_hot & GU_USE_LPID);
            use_pid  = |(quad_hot & GU_USE_PID);
        end
        sel_lpid = use_lpid ? cur_lpid : '0;
        sel_pid  = use_pid  ? cur_pid  : '0;
    end
endmodule

// File: rtl/aqcr_fault_sel.sv
// Module: chooses the segment fault type from the access kind.
// Assumes fail is already the final pass/fail decision.
module aqcr_fault_sel
    import aqcr_pkg::*;
(
    input  logic        fail,
    input  acc_kind_e   kind,
    output fault_kind_e fault,
    output logic        capture
);
    // Fetches get an instruction fault; loads and stores get a data fault
    // and request capture of the address.
    always_comb begin
        fault   = FLT_NONE;
        capture = 1'b0;
        if (fail) begin
            case (kind)
                ACC_LOAD, ACC_STORE: begin
                    fault   = FLT_DSEG;
                    capture = 1'b1;
                end
                default: fault = FLT_ISEG;
            endcase
        end
    end
endmodule

// File: rtl/aqcr_top.sv
// Module: address quadrant context resolver. Samples a request on
// req_valid and presents the ID pair or a segment fault one cycle later.
// Assumes synchronous active-low reset and requests at most one per cycle.
module aqcr_top
    import aqcr_pkg::*;
#(
    parameter int ADDR_W  = 64,
    parameter int VA_BITS = 52,
    parameter int LPID_W  = 12,
    parameter int PID_W   = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_hv,
    input  logic [1:0]        req_kind,
    input  logic [LPID_W-1:0] cur_lpid,
    input  logic [PID_W-1:0]  cur_pid,
    output logic              rsp_done,
    output logic              rsp_ok,
    output logic [LPID_W-1:0] rsp_lpid,
    output logic [PID_W-1:0]  rsp_pid,
    output logic [1:0]        rsp_fault,
    output logic [ADDR_W-1:0] fault_addr
);
    logic [1:0]        quad;
    logic              in_range;
    logic              quad_legal;
    logic [LPID_W-1:0] sel_lpid;
    logic [PID_W-1:0]  sel_pid;
    logic              fail;
    fault_kind_e       fault_nxt;
    logic              capture;

    aqcr_range_chk #(.ADDR_W(ADDR_W), .VA_BITS(VA_BITS)) u_range (
        .hi_bits (req_addr[ADDR_W-1:VA_BITS]),
        .quad    (quad),
        .in_range(in_range)
    );

    aqcr_quad_decode #(.LPID_W(LPID_W), .PID_W(PID_W)) u_quad (
        .quad    (quad),
        .hv      (req_hv),
        .cur_lpid(cur_lpid),
        .cur_pid (cur_pid),
        .legal   (quad_legal),
        .sel_lpid(sel_lpid),
        .sel_pid (sel_pid)
    );

    // Overall decision: address in range and quadrant allowed in this mode.
    assign fail = ~(in_range & quad_legal);

    aqcr_fault_sel u_fault (
        .fail   (fail),
        .kind   (acc_kind_e'(req_kind)),
        .fault  (fault_nxt),
        .capture(capture)
    );

    // Result registers: one-cycle done pulse with the sampled result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_done  <= 1'b0;
            rsp_ok    <= 1'b0;
            rsp_lpid  <= '0;
            rsp_pid   <= '0;
            rsp_fault <= FLT_NONE;
        end else begin
            rsp_done <= req_valid;
            if (req_valid) begin
                rsp_ok    <= ~fail;
                rsp_lpid  <= fail ? '0 : sel_lpid;
                rsp_pid   <= fail ? '0 : sel_pid;
                rsp_fault <= fault_nxt;
            end
        end
    end

    // Fault-address register: loaded only on a data-segment fault.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_addr <= '0;
        end else if (req_valid && capture) begin
            fault_addr <= req_addr;
        end
    end

    // R2
    done_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> $past(req_valid));

    // R3
    hole_rejects_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && |req_addr[ADDR_W-3:VA_BITS]) |=> (rsp_done && !rsp_ok));

    // R7
    guest_quad_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_hv && (req_addr[ADDR_W-1:ADDR_W-2] == 2'b01 ||
                                  req_addr[ADDR_W-1:ADDR_W-2] == 2'b10))
        |=> (!rsp_ok && rsp_fault != FLT_NONE));

    // R8
    iseg_holds_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && rsp_fault == FLT_ISEG) |-> $stable(fault_addr));

    // R9
    dseg_captures_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && rsp_fault == FLT_DSEG) |-> fault_addr == $past(req_addr));

    // R10
    fail_zero_ids_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && !rsp_ok) |-> (rsp_lpid == '0 && rsp_pid == '0 &&
                                   rsp_fault != FLT_NONE));
endmodule

// File: tb/aqcr_top_bench.sv
`timescale 1ns/1ps
module aqcr_top_bench;
    localparam int ADDR_W = 64;
    localparam int LPID_W = 12;
    localparam int PID_W  = 20;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              req_hv = 1'b0;
    logic [1:0]        req_kind = 2'd0;
    logic [LPID_W-1:0] cur_lpid = '0;
    logic [PID_W-1:0]  cur_pid = '0;
    logic              rsp_done;
    logic              rsp_ok;
    logic [LPID_W-1:0] rsp_lpid;
    logic [PID_W-1:0]  rsp_pid;
    logic [1:0]        rsp_fault;
    logic [ADDR_W-1:0] fault_addr;

    int checks = 0;
    int fails  = 0;
    logic [ADDR_W-1:0] model_faddr = '0;

    always #5 clk = ~clk;

    aqcr_top u_aqcr_top (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_hv(req_hv), .req_kind(req_kind), .cur_lpid(cur_lpid),
        .cur_pid(cur_pid), .rsp_done(rsp_done), .rsp_ok(rsp_ok),
        .rsp_lpid(rsp_lpid), .rsp_pid(rsp_pid), .rsp_fault(rsp_fault),
        .fault_addr(fault_addr)
    );

    task automatic check(input bit cond, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!cond) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit exp_ok(logic [63:0] a, logic hv);
        if (|a[61:52]) return 1'b0;
        if (!hv && (a[63:62] == 2'b01 || a[63:62] == 2'b10)) return 1'b0;
        return 1'b1;
    endfunction

    function automatic logic [LPID_W-1:0] exp_lpid(logic [63:0] a, logic hv,
                                                   logic [LPID_W-1:0] l);
        if (!exp_ok(a, hv)) return '0;
        if (hv) return (a[63:62] == 2'b01 || a[63:62] == 2'b10) ? l : '0;
        return l;
    endfunction

    function automatic logic [PID_W-1:0] exp_pid(logic [63:0] a, logic hv,
                                                 logic [PID_W-1:0] p);
        if (!exp_ok(a, hv)) return '0;
        if (hv) return (a[63:62] == 2'b00 || a[63:62] == 2'b01) ? p : '0;
        return (a[63:62] == 2'b00) ? p : '0;
    endfunction

    // Drive one request at a negedge, check its result at the next negedge.
    task automatic run_one(input logic [63:0] a, input logic hv,
                           input logic [1:0] kind, input logic [LPID_W-1:0] l,
                           input logic [PID_W-1:0] p, input string tag);
        bit ok;
        logic [1:0] ef;
        req_valid = 1'b1; req_addr = a; req_hv = hv; req_kind = kind;
        cur_lpid = l; cur_pid = p;
        ok = exp_ok(a, hv);
        ef = ok ? 2'd0 : (kind[1] ? 2'd1 : 2'd2);
        if (!ok && !kind[1]) model_faddr = a;
        @(negedge clk);
        check(rsp_done === 1'b1, {tag, " R2 done"}, 64'(rsp_done), 64'd1);
        check(rsp_ok === ok, {tag, " ok"}, 64'(rsp_ok), 64'(ok));
        check(rsp_lpid === exp_lpid(a, hv, l), {tag, " lpid"},
              64'(rsp_lpid), 64'(exp_lpid(a, hv, l)));
        check(rsp_pid === exp_pid(a, hv, p), {tag, " pid"},
              64'(rsp_pid), 64'(exp_pid(a, hv, p)));
        check(rsp_fault === ef, {tag, " R8/R9 fault type"},
              64'(rsp_fault), 64'(ef));
        check(fault_addr === model_faddr, {tag, " R9/R10 fault_addr"},
              fault_addr, model_faddr);
        req_valid = 1'b0;
    endtask

    task automatic idle_check();
        @(negedge clk);
        check(rsp_done === 1'b0, "R2 no done when idle", 64'(rsp_done), 64'd0);
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240517));
        repeat (3) @(negedge clk);
        check(rsp_done === 1'b0 && rsp_ok === 1'b0 && rsp_fault === 2'd0,
              "R1 reset flags", {60'd0, rsp_done, rsp_ok, rsp_fault}, 64'd0);
        check(rsp_lpid === '0 && rsp_pid === '0 && fault_addr === '0,
              "R1 reset values", fault_addr, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(rsp_done === 1'b0 && fault_addr === '0, "R1 after release",
              {63'd0, rsp_done}, 64'd0);

        // Hypervisor quadrant table.
        run_one(64'h0000_1234_5678_9ABC, 1, 0, 12'hA5C, 20'h1_2345, "R4 hv q0");
        run_one(64'h4000_0000_0000_1000, 1, 1, 12'h3C1, 20'hF_00D1, "R4 hv q1");
        run_one(64'h8000_0000_0000_2000, 1, 2, 12'h7E7, 20'h5_5555, "R5 hv q2");
        run_one(64'hC00F_FFFF_FFFF_FFFF, 1, 0, 12'hFFF, 20'hF_FFFF, "R5 hv q3");
        // Guest quadrant table.
        run_one(64'h000F_FFFF_FFFF_FFF8, 0, 2, 12'h123, 20'hA_BCDE, "R6 gu q0");
        run_one(64'hC000_0000_0000_0040, 0, 1, 12'h456, 20'h0_0777, "R6 gu q3");
        // Guest illegal quadrants with each access kind.
        run_one(64'h4000_0000_DEAD_0000, 0, 0, 12'h111, 20'h2_2222, "R7 gu q1 load");
        run_one(64'h8000_0000_BEEF_0000, 0, 2, 12'h111, 20'h2_2222, "R7 gu q2 fetch R8");
        run_one(64'h8000_0000_CAFE_0008, 0, 1, 12'h111, 20'h2_2222, "R7 gu q2 store R9");
        run_one(64'h4000_0000_0000_0010, 0, 3, 12'h111, 20'h2_2222, "R8 code3 fetch");
        idle_check();
        // Hole bits, single bit at each edge of the hole, both modes.
        run_one(64'h0010_0000_0000_0000, 1, 0, 12'h222, 20'h3_3333, "R3 hole low bit");
        run_one(64'h2000_0000_0000_0000, 1, 2, 12'h222, 20'h3_3333, "R3 hole high bit");
        run_one(64'hC100_0000_0000_0004, 0, 1, 12'h222, 20'h3_3333, "R3 hole guest");
        // Success after a data fault must leave fault_addr alone.
        run_one(64'h0000_0000_0000_0100, 0, 0, 12'h333, 20'h4_4444, "R10 hold");
        idle_check();

        for (int i = 0; i < 600; i++) begin
            logic [63:0] a;
            a = {$urandom, $urandom};
            if ($urandom_range(3) != 0) a[61:52] = '0;
            run_one(a, 1'($urandom_range(1)), 2'($urandom_range(3)),
                    12'($urandom), 20'($urandom), "rand R2-R10");
            if ($urandom_range(7) == 0) idle_check();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule